// File: doc/BRIEF.md
# PCM Time-Division Serial Port Front End

This block is the bit-level edge of a PCM time-division serial highway. It watches an external data clock and a frame sync pulse, recovers bit and frame timing from them, and from then on counts 32 time slots of 8 bits per frame. Received bits are assembled most significant bit first into one byte per slot and handed out with a one-cycle strobe and the slot number. Transmit bytes are pulled in one slot ahead and shifted out most significant bit first, with an output-enable that models tri-state and open-drain pins.

The whole block runs on one system clock at eight times the bit rate. The data clock, frame sync and receive line pass through a two-stage synchroniser, and bit timing is kept by a 3-bit phase counter, so each bit lasts eight system clocks. A 6-bit configuration register, written through a one-cycle write strobe, selects the data-clock ratio, the sync sampling edge, an optional one-data-clock frame delay, the transmit launch point, the receive sampling point and open-drain or push-pull output. All timing below is counted in system clocks from the "reference clock": the system clock edge at which the selected data-clock edge is first present at the pins together with a high frame sync.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset the configuration is 0x00; rx_valid, tx_req, tx_oe and tx_out are low, and they stay low until a frame sync is accepted.
- R2: Configuration bit 0 selects the data-clock ratio: 0 means two data-clock periods per bit (4 system clocks each), 1 means one period per bit (8 system clocks); the ratio sets the length of one data-clock pulse used by R4.
- R3: Configuration bit 1 selects the sync edge: 1 accepts frame sync on a rising data-clock edge, 0 on a falling edge; a sync high only at an edge of the other polarity starts no frame.
- R4: Configuration bit 2 delays the frame start by one data-clock period (4 or 8 system clocks per R2); with bit 2 clear, bit 0 of slot 0 begins at the reference clock. Bit k of the frame begins D + 8k clocks after the reference, D being the delay.
- R5: Configuration bit 3 sets the launch point: with 0, tx_out and tx_oe for bit k change 4 + D + 8k clocks after the reference; with 1, four clocks (half a bit) later.
- R6: Configuration bit 4 sets the sampling point: with 0, bit k takes the value rx_in holds 5 clocks after the bit begins (half a bit, as seen after synchronisation); with 1, the value it holds 7 clocks after (three quarters).
- R7: Configuration bit 5 selects open drain: with 1, a driven slot gives tx_oe = not bit and tx_out = 0; with 0, tx_oe = 1 and tx_out = bit. Bits 7:6 of the write data have no effect.
- R8: Each slot's 8 received bits form rx_byte, first bit as MSB; rx_valid pulses for one cycle with rx_slot, visible 1 clock after the last bit's sample, and the slot number wraps from 31 to 0 without a new sync.
- R9: tx_req pulses for one cycle at the first clock of each slot (3 + D + 64j clocks after the reference for slot j) with tx_req_slot = next slot modulo 32; tx_byte and tx_valid are captured at the end of that cycle for the slot that is starting, and are sent MSB first.
- R10: A slot captured with tx_valid low keeps tx_oe low for all its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| dclk | input | 1 | External data clock |
| fsync | input | 1 | External frame sync |
| rx_in | input | 1 | Serial receive line |
| tx_byte | input | 8 | Transmit byte for the slot being started |
| tx_valid | input | 1 | Transmit byte present; low leaves the slot undriven |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte and rx_slot |
| rx_slot | output | 5 | Slot number of rx_byte |
| tx_req | output | 1 | One-cycle request at each slot start |
| tx_req_slot | output | 5 | Slot whose byte is wanted next |
| tx_out | output | 1 | Serial transmit value |
| tx_oe | output | 1 | Transmit output enable |

## Verification
The bound checker watches, on every cycle, that the receive strobe and the transmit request are single-cycle pulses, that an open-drain launch never raises tx_out, and that nothing leaves reset active. Everything that depends on where the frame starts and when bits are sampled or launched only shows up in the bench's scenarios: it walks every combination of the six configuration bits against a timing model counted from the reference clock, feeds a receive line that changes between the half and three-quarter points, leaves one slot without data, runs a full frame to see the slot number wrap, and offers a sync on the wrong edge.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_W    = 3;
    localparam int PH_W     = 3;
    localparam int SLOTS    = 32;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int CFG_W    = 8;
    localparam int SYNC_W   = 3;

    // Phase positions within one bit (8 system clocks per bit)
    localparam logic [PH_W-1:0] PH_HALF    = PH_W'(4);
    localparam logic [PH_W-1:0] PH_3QTR    = PH_W'(6);
    localparam logic [PH_W-1:0] PH_START   = PH_W'(0);

    // Frame-delay countdown loads (data-clock period minus one)
    localparam logic [PH_W-1:0] WAIT_DOUBLE = PH_W'(3);
    localparam logic [PH_W-1:0] WAIT_SINGLE = PH_W'(7);

    typedef struct packed {
        logic open_drain;
        logic in_late;
        logic out_late;
        logic fr_delay;
        logic fs_rise;
        logic clk_single;
    } cfg_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic [PH_W-1:0]   phase;
    } tpos_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } txw_t;

    function automatic logic [PH_W-1:0] sample_phase(input logic late);
        return late ? PH_3QTR : PH_HALF;
    endfunction

    function automatic logic [PH_W-1:0] launch_phase(input logic late);
        return late ? PH_HALF : PH_START;
    endfunction

    function automatic logic [PH_W-1:0] delay_load(input logic single);
        return single ? WAIT_SINGLE : WAIT_DOUBLE;
    endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pcm_timebase.sv
module pcm_timebase
    import pcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fr_delay,
    input  logic  clk_single,
    input  logic  sync_ev,
    output tpos_t pos,
    output logic  aligned
);
    localparam int POS_W = $bits(tpos_t);

    logic            pend;
    logic [PH_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            aligned <= 1'b0;
            pend    <= 1'b0;
            wcnt    <= '0;
        end else begin
            pos <= tpos_t'(pos + POS_W'(1));
            if (sync_ev && !fr_delay) begin
                pos     <= '0;
                aligned <= 1'b1;
                pend    <= 1'b0;
            end else if (sync_ev) begin
                pend <= 1'b1;
                wcnt <= delay_load(clk_single);
            end else if (pend) begin
                if (wcnt == '0) begin
                    pos     <= '0;
                    aligned <= 1'b1;
                    pend    <= 1'b0;
                end else begin
                    wcnt <= wcnt - PH_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_late,
    input  tpos_t             pos,
    input  logic              aligned,
    input  logic              rx_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [SLOT_W-1:0] rx_slot
);
    logic [BYTE_W-1:0] shreg;
    logic              take;

    assign take = aligned && (pos.phase == sample_phase(in_late));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                shreg <= {shreg[BYTE_W-2:0], rx_bit};
                if (pos.bitn == BIT_W'(BYTE_W - 1)) begin
                    rx_byte  <= {shreg[BYTE_W-2:0], rx_bit};
                    rx_valid <= 1'b1;
                    rx_slot  <= pos.slot;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
    import pcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              out_late,
    input  logic              open_drain,
    input  tpos_t             pos,
    input  logic              aligned,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_req,
    output logic [SLOT_W-1:0] tx_req_slot,
    output logic              tx_out,
    output logic              tx_oe
);
    txw_t held;
    txw_t cur;
    logic boundary;
    logic launch;
    logic bitv;

    assign boundary    = aligned && (pos.phase == PH_START) && (pos.bitn == '0);
    assign launch      = aligned && (pos.phase == launch_phase(out_late));
    assign tx_req      = boundary;
    assign tx_req_slot = pos.slot + SLOT_W'(1);

    // First bit of a slot launches in the same cycle the byte is captured
    assign cur  = boundary ? txw_t'({tx_valid, tx_byte}) : held;
    assign bitv = cur.data[~pos.bitn];

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            tx_out <= 1'b0;
            tx_oe  <= 1'b0;
        end else begin
            if (boundary) begin
                held <= txw_t'({tx_valid, tx_byte});
            end
            if (launch) begin
                tx_oe  <= cur.valid & (open_drain ? ~bitv : 1'b1);
                tx_out <= open_drain ? 1'b0 : bitv;
            end
        end
    end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
    import pcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dclk,
    input  logic              fsync,
    input  logic              rx_in,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              tx_req,
    output logic [SLOT_W-1:0] tx_req_slot,
    output logic              tx_out,
    output logic              tx_oe
);
    localparam int CFG_USED = $bits(cfg_t);

    cfg_t              cfg_q;
    logic              unused_cfg_bits;
    logic [SYNC_W-1:0] sync_q;
    logic              dclk_d;
    logic              dclk_rise;
    logic              dclk_fall;
    logic              sync_ev;
    tpos_t             pos;
    logic              aligned;

    assign unused_cfg_bits = ^cfg_wdata[CFG_W-1:CFG_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            dclk_d <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_t'(cfg_wdata[CFG_USED-1:0]);
            end
            dclk_d <= sync_q[0];
        end
    end

    pcm_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rx_in, fsync, dclk}),
        .q   (sync_q)
    );

    assign dclk_rise = sync_q[0] & ~dclk_d;
    assign dclk_fall = ~sync_q[0] & dclk_d;
    assign sync_ev   = sync_q[1] & (cfg_q.fs_rise ? dclk_rise : dclk_fall);

    pcm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .fr_delay   (cfg_q.fr_delay),
        .clk_single (cfg_q.clk_single),
        .sync_ev    (sync_ev),
        .pos        (pos),
        .aligned    (aligned)
    );

    pcm_rx_deser u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_late  (cfg_q.in_late),
        .pos      (pos),
        .aligned  (aligned),
        .rx_bit   (sync_q[2]),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_slot  (rx_slot)
    );

    pcm_tx_ser u_tx (
        .clk         (clk),
        .rst         (rst),
        .out_late    (cfg_q.out_late),
        .open_drain  (cfg_q.open_drain),
        .pos         (pos),
        .aligned     (aligned),
        .tx_byte     (tx_byte),
        .tx_valid    (tx_valid),
        .tx_req      (tx_req),
        .tx_req_slot (tx_req_slot),
        .tx_out      (tx_out),
        .tx_oe       (tx_oe)
    );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk
    import pcm_pkg::*;
(
    input logic clk,
    input logic rst,
    input cfg_t cfg_q,
    input logic rx_valid,
    input logic tx_req,
    input logic tx_out,
    input logic tx_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_valid && !tx_req && !tx_oe && !tx_out));

    assert_od_no_high_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_out) |-> !$past(cfg_q.open_drain));

    assert_od_enable_low_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_oe) && $past(cfg_q.open_drain)) |-> !tx_out);

    assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);
endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_q    (cfg_q),
    .rx_valid (rx_valid),
    .tx_req   (tx_req),
    .tx_out   (tx_out),
    .tx_oe    (tx_oe)
);

// File: tb/pcm_tdm_port_tb.sv
module pcm_tdm_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       dclk;
    logic       fsync;
    logic       rx_in;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic [4:0] rx_slot;
    logic       tx_req;
    logic [4:0] tx_req_slot;
    logic       tx_out;
    logic       tx_oe;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 0;

    // {cfg, frame delay in clocks, late sampling, launch offset}
    localparam logic [31:0] VEC [8] = '{
        {8'h00, 8'd0, 8'd0, 8'd0},
        {8'h04, 8'd4, 8'd0, 8'd0},
        {8'h05, 8'd8, 8'd0, 8'd0},
        {8'h06, 8'd4, 8'd0, 8'd0},
        {8'h08, 8'd0, 8'd0, 8'd4},
        {8'h10, 8'd0, 8'd1, 8'd0},
        {8'h20, 8'd0, 8'd0, 8'd0},
        {8'h3F, 8'd8, 8'd1, 8'd4}
    };

    always #10 clk = ~clk;

    pcm_tdm_port u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dclk(dclk), .fsync(fsync), .rx_in(rx_in),
        .tx_byte(tx_byte), .tx_valid(tx_valid),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_slot(rx_slot),
        .tx_req(tx_req), .tx_req_slot(tx_req_slot),
        .tx_out(tx_out), .tx_oe(tx_oe)
    );

    function automatic logic [7:0] pat_a(input int j);
        return 8'(8'hA5 ^ ((j % 32) * 37));
    endfunction
    function automatic logic [7:0] pat_b(input int j);
        return ~pat_a(j);
    endfunction
    function automatic logic [7:0] pat_tx(input int j);
        return 8'(90 + (j % 32) * 29);
    endfunction
    function automatic logic pat_txv(input int j);
        return (j % 32) != 1;
    endfunction
    function automatic logic dclk_at(input int t, input logic single, input logic rise);
        int per;
        logic hi;
        per = single ? 8 : 4;
        hi  = ((t + 64) % per) < (per / 2);
        return rise ? hi : ~hi;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; dclk = 1'b0; fsync = 1'b0;
        rx_in = 1'b0; tx_byte = '0; tx_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One frame run; t counts system clocks from the reference clock
    task automatic run_frame(input logic [7:0] c, input bit wr, input int d,
                             input bit late, input int lph, input int ns);
        int  tend, q, j, k, b, r, o;
        bit  e, pend;
        int  pj;
        logic [7:0] ea, eb, et;
        logic v, val, eoe, eout;
        tend = 12 + d + 64 * ns;
        pend = 0; pj = 0;
        tx_byte = pat_tx(0); tx_valid = pat_txv(0);
        for (int t = -16; t <= tend; t++) begin
            if (t >= 4 + d) begin
                q = t - 4 - d - (late ? 6 : 4);
                e = (q >= 0) && (q % 64 == 56) && (q / 64 < ns);
                chk(rx_valid == e, "R4/R8 rx strobe", int'(rx_valid), int'(e));
                if (e) begin
                    j = q / 64;
                    ea = pat_a(j); eb = pat_b(j);
                    chk(rx_slot == 5'(j % 32), "R8 rx slot", int'(rx_slot), j % 32);
                    chk(rx_byte == (late ? eb : ea), "R6/R8 rx byte",
                        int'(rx_byte), int'(late ? eb : ea));
                end
            end
            if (t >= 4 + d + lph && t < 4 + d + lph + 64 * ns) begin
                k = (t - 4 - d - lph) / 8;
                j = k / 8; b = k % 8;
                et = pat_tx(j); v = et[7 - b]; val = pat_txv(j);
                eoe  = val & (c[5] ? ~v : 1'b1);
                eout = c[5] ? 1'b0 : v;
                chk(tx_oe == eoe, "R2/R4/R5/R7/R10 tx_oe", int'(tx_oe), int'(eoe));
                chk(tx_out == eout, "R5/R7 tx_out", int'(tx_out), int'(eout));
            end
            if (t >= 3 + d && t < 3 + d + 64 * ns) begin
                e = ((t - 3 - d) % 64) == 0;
                chk(tx_req == e, "R9 tx_req", int'(tx_req), int'(e));
                if (e) chk(tx_req_slot == 5'(((t - 3 - d) / 64 + 1) % 32), "R9 req slot",
                           int'(tx_req_slot), ((t - 3 - d) / 64 + 1) % 32);
            end
            if (pend) begin
                tx_byte = pat_tx(pj); tx_valid = pat_txv(pj); pend = 0;
            end
            if (t >= 3 + d && tx_req) begin
                pend = 1; pj = (t - 3 - d) / 64 + 1;
            end
            cfg_we = wr && (t == -16);
            cfg_wdata = c;
            dclk  = dclk_at(t, c[0], c[1]);
            fsync = (t == 0);
            r = t - d;
            if (r >= 0 && r < 64 * ns) begin
                k = r / 8; o = r % 8; j = k / 8; b = k % 8;
                ea = pat_a(j); eb = pat_b(j);
                rx_in = (o <= 5) ? ea[7 - b] : eb[7 - b];
            end else begin
                rx_in = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] vv;
        int dd;
        do_reset();
        // R1: quiet outputs after reset
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        chk(tx_req == 1'b0, "R1 tx_req", int'(tx_req), 0);
        chk(tx_oe == 1'b0, "R1 tx_oe", int'(tx_oe), 0);
        chk(tx_out == 1'b0, "R1 tx_out", int'(tx_out), 0);
        // R1: reset configuration acts as 0x00 without any write
        run_frame(8'h00, 1'b0, 0, 1'b0, 0, 3);

        // R3: sync on the wrong edge starts nothing
        do_reset();
        for (int t = -16; t <= 150; t++) begin
            if (t >= 0) begin
                chk(tx_req == 1'b0, "R3 wrong edge tx_req", int'(tx_req), 0);
                chk(rx_valid == 1'b0, "R3 wrong edge rx_valid", int'(rx_valid), 0);
                chk(tx_oe == 1'b0, "R3 wrong edge tx_oe", int'(tx_oe), 0);
            end
            cfg_we = (t == -16); cfg_wdata = 8'h02;
            dclk = dclk_at(t, 1'b0, 1'b0);
            fsync = (t == 0);
            rx_in = 1'b1;
            @(negedge clk);
        end
        cfg_we = 1'b0;

        // Table of vectors with written-out expected timing
        for (int i = 0; i < 8; i++) begin
            vv = VEC[i];
            run_frame(vv[31:24], 1'b1, int'(vv[23:16]), vv[8], int'(vv[7:0]), 3);
        end

        // Every combination of the six configuration bits, spare bits set
        for (int c = 0; c < 64; c++) begin
            dd = c[2] ? (c[0] ? 8 : 4) : 0;
            run_frame(8'(c) | 8'hC0, 1'b1, dd, c[4], c[3] ? 4 : 0, 3);
        end

        // R8 / R9: full frame to see slot 31 wrap to 0
        run_frame(8'h01, 1'b1, 0, 1'b0, 0, 33);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule